// File: doc/BRIEF.md
# Sub-word Load/Store Aligner

This block sits between a load/store pipeline stage and a data memory organised as rows of eight bytes. Each request carries a byte address, an access size (1, 2, 4 or 8 bytes), a byte-reversal flag and, for stores, the data to write. The block splits the address into a row number and a byte offset. It then extracts the addressed lanes from the row on a load, or merges new lanes into the row on a store.

Loads return their lanes zero-extended to the full row width, with an optional reversal of byte order inside the accessed size. Stores apply the reversal first and then replace only the addressed lanes by a read-modify-write. A store that covers the whole row is written directly. A request whose offset is not a multiple of its size is refused: it raises an error pulse and touches nothing. The row storage is part of the block, and a row that has never been written reads as zero.

Top module: `lsu_subword_align`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1 and both `rsp_valid` and `misalign_err` are 0.
- R2: The row number is the address bits above the lowest three. The byte offset is the lowest three address bits. Rows are independent of each other.
- R3: An access is misaligned when the offset ANDed with (size in bytes - 1) is nonzero. It is still accepted. `misalign_err` is 1 for the cycle after the accepting edge, no response is produced, no row changes and `req_ready` stays 1.
- R4: `req_size` selects 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A load returns the bytes at offset..offset+size-1 with the lowest-addressed byte in bits 7:0, zero-extended to 64 bits. `rsp_valid` is 1 for exactly one cycle, set by the clock edge after the accepting edge.
- R5: A store narrower than a row changes only the addressed bytes. The other bytes of the row keep their values.
- R6: An 8-byte store replaces the whole row, and `req_ready` stays 1 after it is accepted.
- R7: With `req_swap` = 1, a load returns the extracted bytes in reversed order within the access size.
- R8: With `req_swap` = 1, a store reverses the low size bytes of `req_wdata` before writing them.
- R9: Bits of `req_wdata` above the access size have no effect on memory.
- R10: A row that has never been written reads as zero.
- R11: After it accepts a load or a narrower-than-row aligned store, `req_ready` is 0 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 7 | Byte address (row number, then 3-bit offset) |
| req_size | input | 2 | Access size code: 0..3 for 1, 2, 4, 8 bytes |
| req_swap | input | 1 | Reverse byte order within the access |
| req_wdata | input | 64 | Store data, lanes in the low bytes |
| rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| rsp_data | output | 64 | Zero-extended load data |
| misalign_err | output | 1 | Misaligned request refused (one-cycle pulse) |

## Verification
The bench builds the block with its default eight-byte rows and sixteen rows, so addresses are seven bits wide. This makes the first and last rows both reachable. It also lets a short loop walk every aligned offset of every access size within one row. A reference model of the rows, kept as plain byte arrays in the bench, provides the expected value of each load after mixed narrow, full, reversed and refused stores.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    // Two-phase request engine: idle accepts, busy finishes the row access.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } phase_e;

endpackage

// File: rtl/lsa_row_store.sv
module lsa_row_store #(
    parameter int ROW_W = 64,
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ROW_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ROW_W-1:0] wr_data
);
    logic [ROW_W-1:0] rows [DEPTH];
    logic [DEPTH-1:0] written_q;
    logic [ROW_W-1:0] rd_q;

    // Row contents carry no reset; the written flags make fresh rows read zero.
    always_ff @(posedge clk) begin
        if (wr_en) rows[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            written_q <= '0;
            rd_q      <= '0;
        end else begin
            if (wr_en) written_q[wr_idx] <= 1'b1;
            if (rd_en) rd_q <= written_q[rd_idx] ? rows[rd_idx] : '0;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/lsa_lane_order.sv
module lsa_lane_order #(
    parameter int ROW_BYTES = 8,
    localparam int OFF_W = $clog2(ROW_BYTES),
    localparam int SIZES = OFF_W + 1,
    localparam int SZ_W  = $clog2(SIZES),
    localparam int ROW_W = 8 * ROW_BYTES
) (
    input  logic [ROW_W-1:0] din,
    input  logic [SZ_W-1:0]  size,
    input  logic             swap,
    output logic [ROW_W-1:0] dout
);
    // Per size: low lanes kept as they are, or mirrored; upper lanes cleared.
    logic [SIZES-1:0][ROW_W-1:0] kept;
    logic [SIZES-1:0][ROW_W-1:0] mirrored;

    for (genvar s = 0; s < SIZES; s++) begin : g_size
        localparam int NB = 1 << s;
        for (genvar b = 0; b < ROW_BYTES; b++) begin : g_lane
            if (b < NB) begin : g_in
                assign kept[s][b*8 +: 8]     = din[b*8 +: 8];
                assign mirrored[s][b*8 +: 8] = din[(NB-1-b)*8 +: 8];
            end else begin : g_out
                assign kept[s][b*8 +: 8]     = 8'h00;
                assign mirrored[s][b*8 +: 8] = 8'h00;
            end
        end
    end

    assign dout = swap ? mirrored[size] : kept[size];

endmodule

// File: rtl/lsa_field_unit.sv
module lsa_field_unit #(
    parameter int ROW_BYTES = 8,
    localparam int OFF_W = $clog2(ROW_BYTES),
    localparam int SIZES = OFF_W + 1,
    localparam int SZ_W  = $clog2(SIZES),
    localparam int ROW_W = 8 * ROW_BYTES
) (
    input  logic [ROW_W-1:0] row,
    input  logic [OFF_W-1:0] off,
    input  logic [SZ_W-1:0]  size,
    input  logic [ROW_W-1:0] ins,
    output logic [ROW_W-1:0] extracted,
    output logic [ROW_W-1:0] merged
);
    logic [SIZES-1:0][ROW_W-1:0] mask_tab;
    logic [OFF_W+2:0]            bit_sh;
    logic [ROW_W-1:0]            fmask;

    for (genvar s = 0; s < SIZES; s++) begin : g_mask
        if ((8 << s) >= ROW_W) begin : g_full
            assign mask_tab[s] = '1;
        end else begin : g_part
            assign mask_tab[s] = {{(ROW_W - (8 << s)){1'b0}}, {(8 << s){1'b1}}};
        end
    end

    assign bit_sh    = {off, 3'b000};
    assign fmask     = mask_tab[size];
    assign extracted = (row >> bit_sh) & fmask;
    assign merged    = (row & ~(fmask << bit_sh)) | ((ins & fmask) << bit_sh);

endmodule

// File: rtl/lsu_subword_align.sv
module lsu_subword_align
    import lsa_pkg::*;
#(
    parameter int ROW_BYTES = 8,
    parameter int DEPTH     = 16,
    localparam int OFF_W  = $clog2(ROW_BYTES),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int ADDR_W = IDX_W + OFF_W,
    localparam int ROW_W  = 8 * ROW_BYTES,
    localparam int SZ_W   = $clog2(OFF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SZ_W-1:0]   req_size,
    input  logic              req_swap,
    input  logic [ROW_W-1:0]  req_wdata,
    output logic              rsp_valid,
    output logic [ROW_W-1:0]  rsp_data,
    output logic              misalign_err
);
    typedef struct packed {
        phase_e           ph;
        logic             st;
        logic             swp;
        logic [SZ_W-1:0]  sz;
        logic [OFF_W-1:0] off;
        logic [IDX_W-1:0] idx;
        logic [ROW_W-1:0] sval;
        logic             rv;
        logic [ROW_W-1:0] rdata;
        logic             err;
    } state_t;

    state_t s_d, s_q;

    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] req_idx;
    logic [OFF_W-1:0] size_lowmask;
    logic             aligned, full_sz, accept;

    logic             m_rd_en, m_wr_en;
    logic [IDX_W-1:0] m_rd_idx, m_wr_idx;
    logic [ROW_W-1:0] m_rd_data, m_wr_data;
    logic [ROW_W-1:0] st_lanes, ld_raw, ld_lanes, row_merged;

    assign req_off      = req_addr[OFF_W-1:0];
    assign req_idx      = req_addr[ADDR_W-1:OFF_W];
    assign size_lowmask = ~({OFF_W{1'b1}} << req_size);
    assign aligned      = (req_off & size_lowmask) == '0;
    assign full_sz      = (req_size == SZ_W'(OFF_W));
    assign accept       = req_valid && (s_q.ph == PH_IDLE);

    lsa_row_store #(.ROW_W(ROW_W), .DEPTH(DEPTH)) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (m_rd_en),
        .rd_idx  (m_rd_idx),
        .rd_data (m_rd_data),
        .wr_en   (m_wr_en),
        .wr_idx  (m_wr_idx),
        .wr_data (m_wr_data)
    );

    // Store lanes are put in order (and trimmed) as the request arrives.
    lsa_lane_order #(.ROW_BYTES(ROW_BYTES)) u_st_order (
        .din  (req_wdata),
        .size (req_size),
        .swap (req_swap),
        .dout (st_lanes)
    );

    lsa_field_unit #(.ROW_BYTES(ROW_BYTES)) u_field (
        .row       (m_rd_data),
        .off       (s_q.off),
        .size      (s_q.sz),
        .ins       (s_q.sval),
        .extracted (ld_raw),
        .merged    (row_merged)
    );

    // Load lanes are put in order after extraction.
    lsa_lane_order #(.ROW_BYTES(ROW_BYTES)) u_ld_order (
        .din  (ld_raw),
        .size (s_q.sz),
        .swap (s_q.swp),
        .dout (ld_lanes)
    );

    always_comb begin
        s_d       = s_q;
        s_d.rv    = 1'b0;
        s_d.err   = 1'b0;
        m_rd_en   = 1'b0;
        m_rd_idx  = req_idx;
        m_wr_en   = 1'b0;
        m_wr_idx  = req_idx;
        m_wr_data = st_lanes;

        if (accept) begin
            if (!aligned) begin
                s_d.err = 1'b1;
            end else if (req_store && full_sz) begin
                m_wr_en = 1'b1;
            end else begin
                m_rd_en  = 1'b1;
                s_d.ph   = PH_BUSY;
                s_d.st   = req_store;
                s_d.swp  = req_swap;
                s_d.sz   = req_size;
                s_d.off  = req_off;
                s_d.idx  = req_idx;
                s_d.sval = st_lanes;
            end
        end

        if (s_q.ph == PH_BUSY) begin
            s_d.ph = PH_IDLE;
            if (s_q.st) begin
                m_wr_en   = 1'b1;
                m_wr_idx  = s_q.idx;
                m_wr_data = row_merged;
            end else begin
                s_d.rv    = 1'b1;
                s_d.rdata = ld_lanes;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready    = (s_q.ph == PH_IDLE);
    assign rsp_valid    = s_q.rv;
    assign rsp_data     = s_q.rdata;
    assign misalign_err = s_q.err;

endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
    parameter int OFF_W = 3,
    parameter int SZ_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_store,
    input logic [OFF_W-1:0] req_off,
    input logic [SZ_W-1:0]  req_size,
    input logic             rsp_valid,
    input logic             misalign_err
);
    logic taken, bad, whole;

    assign taken = req_valid && req_ready;
    assign bad   = (req_off & ~({OFF_W{1'b1}} << req_size)) != '0;
    assign whole = (req_size == SZ_W'(OFF_W));

    p_err_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |-> $past(taken));

    p_err_no_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |-> !rsp_valid);

    p_bad_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && bad) |=> (req_ready && misalign_err && !rsp_valid));

    p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_rsp_after_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!req_ready));

    p_full_store_flow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !bad && req_store && whole) |=> (req_ready && !misalign_err));

    p_stall_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    p_stall_on_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !bad && !(req_store && whole)) |=> !req_ready);

endmodule

bind lsu_subword_align lsa_checker #(.OFF_W(OFF_W), .SZ_W(SZ_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_store    (req_store),
    .req_off      (req_addr[OFF_W-1:0]),
    .req_size     (req_size),
    .rsp_valid    (rsp_valid),
    .misalign_err (misalign_err)
);

// File: tb/lsu_subword_align_test.sv
module lsu_subword_align_test;
    localparam int ADDR_W = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_store = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_swap = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        misalign_err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [63:0] model [16];

    always #10 clk = ~clk;

    lsu_subword_align uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_store(req_store), .req_addr(req_addr), .req_size(req_size),
        .req_swap(req_swap), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .misalign_err(misalign_err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] order_bytes(logic [63:0] d, int n, bit swp);
        logic [63:0] o = '0;
        for (int i = 0; i < n; i++)
            o[i*8 +: 8] = swp ? d[(n-1-i)*8 +: 8] : d[i*8 +: 8];
        return o;
    endfunction

    function automatic logic [63:0] exp_load(int idx, int off, int sz, bit swp);
        logic [63:0] raw = '0;
        int n = 1 << sz;
        for (int i = 0; i < n; i++) raw[i*8 +: 8] = model[idx][(off+i)*8 +: 8];
        return order_bytes(raw, n, swp);
    endfunction

    task automatic issue(bit st, int idx, int off, int sz, bit swp, logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_store = st;
        req_addr  = ADDR_W'(idx * 8 + off);
        req_size  = 2'(sz);
        req_swap  = swp;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_load(int idx, int off, int sz, bit swp, string tag);
        logic [63:0] e = exp_load(idx, off, sz, swp);
        issue(1'b0, idx, off, sz, swp, '0);
        check(req_ready == 1'b0, "R11 load stall", 64'(req_ready), 64'd0);
        @(negedge clk);
        check(rsp_valid && rsp_data == e, tag, rsp_data, e);
        @(negedge clk);
        check(rsp_valid == 1'b0 && req_ready, "R4 pulse ends", 64'(rsp_valid), 64'd0);
    endtask

    task automatic do_store(int idx, int off, int sz, bit swp, logic [63:0] wd);
        logic [63:0] v = order_bytes(wd, 1 << sz, swp);
        for (int i = 0; i < (1 << sz); i++) model[idx][(off+i)*8 +: 8] = v[i*8 +: 8];
        issue(1'b1, idx, off, sz, swp, wd);
        if (sz == 3) begin
            check(req_ready == 1'b1, "R6 no stall", 64'(req_ready), 64'd1);
        end else begin
            check(req_ready == 1'b0, "R11 store stall", 64'(req_ready), 64'd0);
            @(negedge clk);
            check(req_ready == 1'b1, "R11 stall one cycle", 64'(req_ready), 64'd1);
        end
    endtask

    task automatic do_bad(bit st, int idx, int off, int sz);
        issue(st, idx, off, sz, 1'b0, 64'hDEAD_BEEF_CAFE_F00D);
        check(misalign_err && !rsp_valid && req_ready, "R3 error pulse",
              {61'd0, misalign_err, rsp_valid, req_ready}, 64'd5);
        @(negedge clk);
        check(!misalign_err && !rsp_valid, "R3 pulse ends",
              {62'd0, misalign_err, rsp_valid}, 64'd0);
    endtask

    task automatic t_reset();
        check(req_ready && !rsp_valid && !misalign_err, "R1 during reset",
              {61'd0, req_ready, rsp_valid, misalign_err}, 64'd4);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !misalign_err, "R1 after reset",
              {61'd0, req_ready, rsp_valid, misalign_err}, 64'd4);
    endtask

    task automatic t_unwritten();
        do_load(5, 0, 3, 1'b0, "R10 fresh row full");
        do_load(9, 4, 2, 1'b0, "R10 fresh row word");
    endtask

    task automatic t_full_and_walk();
        do_store(2, 0, 3, 1'b0, 64'h0123_4567_89AB_CDEF);
        do_load(2, 0, 3, 1'b0, "R6 full row readback");
        for (int sz = 0; sz < 4; sz++)
            for (int off = 0; off < 8; off += (1 << sz))
                do_load(2, off, sz, 1'b0, "R4 lane extract");
    endtask

    task automatic t_partial_store();
        do_store(2, 2, 1, 1'b0, 64'hFFFF_FFFF_FFFF_A5B6);
        do_load(2, 0, 3, 1'b0, "R5 R9 half merge");
        do_store(2, 7, 0, 1'b0, 64'h1234_5678_9ABC_DE3C);
        do_store(2, 4, 2, 1'b0, 64'h7777_7777_0BAD_F00D);
        do_load(2, 0, 3, 1'b0, "R5 R9 byte and word merge");
    endtask

    task automatic t_swap();
        do_load(2, 0, 2, 1'b1, "R7 swapped word");
        do_load(2, 6, 1, 1'b1, "R7 swapped half");
        do_load(2, 0, 3, 1'b1, "R7 swapped row");
        do_store(3, 4, 2, 1'b1, 64'hAAAA_AAAA_1122_3344);
        do_load(3, 0, 3, 1'b0, "R8 swapped word store");
        do_store(4, 0, 3, 1'b1, 64'h0102_0304_0506_0708);
        do_load(4, 0, 3, 1'b0, "R8 swapped row store");
    endtask

    task automatic t_misaligned();
        do_bad(1'b1, 2, 1, 1);
        do_bad(1'b0, 2, 2, 2);
        do_bad(1'b1, 2, 4, 3);
        do_load(2, 0, 3, 1'b0, "R3 row untouched");
        do_bad(1'b1, 6, 3, 2);
        do_load(6, 0, 3, 1'b0, "R3 R10 row stays fresh");
    endtask

    task automatic t_rows();
        do_store(0, 0, 3, 1'b0, 64'h1111_2222_3333_4444);
        do_store(15, 0, 3, 1'b0, 64'h9999_8888_7777_6666);
        do_store(15, 6, 1, 1'b0, 64'h0000_0000_0000_5A5A);
        do_load(0, 0, 3, 1'b0, "R2 first row");
        do_load(15, 0, 3, 1'b0, "R2 last row");
        do_load(1, 0, 3, 1'b0, "R2 neighbour row");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_unwritten();
        t_full_and_walk();
        t_partial_store();
        t_swap();
        t_misaligned();
        t_rows();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule